// File: doc/BRIEF.md
# Soft-Start Voltage Ramp Generator

This block produces the digital output-voltage code that a regulator's reference DAC follows during soft-start. When a start pulse arrives, the code is loaded with a start value. It then climbs toward a target value in fixed increments. Each increment is held for a dwell time derived from the 2 MHz regulator clock.

A 2-bit rate select chooses the dwell as 16, 32, 48 or 64 clock periods, which is 8, 16, 24 or 32 µs. A step-size select picks one code (25 mV) or two codes (50 mV) per step. The block never overshoots the target. It raises a single-cycle done pulse when the target is reached and then holds the code until the next start.

Top module: `ss_ramp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `code_o` is 0 and `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse sampled high while not busy, with target above start code, sets `code_o` to `start_code_i` and `busy_o` to 1 in the following cycle.
- R3: The dwell per step is 16×(rate+1) clock cycles for `rate_i` values 0,1,2,3 (16, 32, 48, 64). Step k takes effect k dwell periods after the accepting clock edge.
- R4: `wide_step_i`=0 advances the code by 1 per step; `wide_step_i`=1 advances it by 2.
- R5: The last step saturates at the target: `code_o` never exceeds the target during a ramp, even when the remaining distance is smaller than the step.
- R6: `done_o` is high for exactly the one cycle in which `code_o` first equals the target. `busy_o` falls in that same cycle.
- R7: After completion, `code_o` keeps the target value until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is high is ignored. Code sequence, timing and target are unchanged.
- R9: If `target_code_i` ≤ `start_code_i` at an accepted start, `code_o` equals the target in the next cycle, `done_o` pulses in that cycle and `busy_o` stays 0.
- R10: `rate_i` and `wide_step_i` are sampled at the accepted start. Changing them during a ramp has no effect on that ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz regulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| rate_i | input | 2 | Dwell select: 16/32/48/64 cycles per step |
| wide_step_i | input | 1 | 0: one-code step, 1: two-code step |
| start_code_i | input | 8 | Initial voltage code |
| target_code_i | input | 8 | Final voltage code |
| code_o | output | 8 | Current voltage code (LSB = 25 mV) |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle pulse when target reached |

## Verification
Directed ramps cover every rate code, which separates the four dwell lengths. They also cover both step sizes with odd and even distances, so a correct increment can be told apart from a missing final saturation. Targets equal to and below the start code exercise the direct-jump path. Some ramps receive a second start pulse and altered rate and step inputs mid-flight; these expose any resampling or restart. Seeded random ramps over short distances mix all these settings and are compared cycle by cycle against a computed code trajectory.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
  parameter int CODE_W   = 8;
  parameter int RATE_W   = 2;
  parameter int DIV_UNIT = 16;
  localparam int MAX_PERIOD = DIV_UNIT * (2 ** RATE_W);
  localparam int PER_W      = $clog2(MAX_PERIOD) + 1;

  typedef enum logic {ST_IDLE = 1'b0, ST_RAMP = 1'b1} ramp_state_e;
endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer
  import ss_ramp_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int DU = DIV_UNIT,
  parameter int PW = PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o
);
  logic [PW-1:0] period;
  logic [PW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    period = PW'((int'(rate_i) + 1) * DU);
    tick_o = run_i && (cnt_q == period - PW'(1));
    cnt_en = clear_i || run_i;
    if (clear_i)     cnt_n = '0;
    else if (tick_o) cnt_n = '0;
    else             cnt_n = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R3
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q < period);
endmodule

// File: rtl/ss_step_calc.sv
module ss_step_calc
  import ss_ramp_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] tgt_i,
  input  logic          wide_i,
  output logic [CW-1:0] nxt_o,
  output logic          reached_o
);
  logic [CW-1:0] step;
  logic [CW-1:0] gap;

  always_comb begin
    step      = wide_i ? CW'(2) : CW'(1);
    gap       = (tgt_i > cur_i) ? (tgt_i - cur_i) : '0;
    reached_o = (gap <= step);
    nxt_o     = reached_o ? tgt_i : (cur_i + step);
  end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp
  import ss_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              wide_step_i,
  input  logic [CODE_W-1:0] start_code_i,
  input  logic [CODE_W-1:0] target_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o
);
  ramp_state_e       state_q, state_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [CODE_W-1:0] tgt_q, tgt_n;
  logic [RATE_W-1:0] rate_q, rate_n;
  logic              wide_q, wide_n;
  logic              done_q, done_n;
  logic              accept, tick, reached, cfg_en;
  logic [CODE_W-1:0] step_code;

  ss_dwell_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .run_i   (state_q == ST_RAMP),
    .rate_i  (rate_q),
    .tick_o  (tick)
  );

  ss_step_calc u_step (
    .cur_i     (code_q),
    .tgt_i     (tgt_q),
    .wide_i    (wide_q),
    .nxt_o     (step_code),
    .reached_o (reached)
  );

  always_comb begin
    accept  = start_i && (state_q == ST_IDLE);
    cfg_en  = accept;
    state_n = state_q;
    code_n  = code_q;
    tgt_n   = target_code_i;
    rate_n  = rate_i;
    wide_n  = wide_step_i;
    done_n  = 1'b0;
    if (accept) begin
      if (target_code_i <= start_code_i) begin
        code_n = target_code_i;
        done_n = 1'b1;
      end else begin
        code_n  = start_code_i;
        state_n = ST_RAMP;
      end
    end else if (state_q == ST_RAMP && tick) begin
      code_n = step_code;
      if (reached) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      rate_q <= '0;
      wide_q <= 1'b0;
    end else if (cfg_en) begin
      tgt_q  <= tgt_n;
      rate_q <= rate_n;
      wide_q <= wide_n;
    end
  end

  assign code_o = code_q;
  assign busy_o = (state_q == ST_RAMP);
  assign done_o = done_q;

  // R5
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> code_o < tgt_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && code_o == tgt_q));

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick && !start_i) |=> $stable(code_o));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tick) |=> (code_o - $past(code_o)) <= (wide_q ? CODE_W'(2) : CODE_W'(1)));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(rate_q) && $stable(wide_q)));
endmodule

// File: tb/test_ss_ramp.sv
module test_ss_ramp;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] rate_i;
  logic       wide_step_i;
  logic [7:0] start_code_i;
  logic [7:0] target_code_i;
  logic [7:0] code_o;
  logic       busy_o;
  logic       done_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ss_ramp i_ss_ramp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
    .wide_step_i(wide_step_i), .start_code_i(start_code_i),
    .target_code_i(target_code_i), .code_o(code_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int exp_code(int s, int tg, int w, int p, int t);
    int v;
    if (tg <= s) return tg;
    v = s + (w ? 2 : 1) * (t / p);
    return (v > tg) ? tg : v;
  endfunction

  function automatic int n_steps(int s, int tg, int w);
    int st;
    st = w ? 2 : 1;
    if (tg <= s) return 0;
    return (tg - s + st - 1) / st;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // disturb: 0 none, 1 extra start mid-ramp (R8), 2 change rate/step mid-ramp (R10)
  task automatic run_ramp(string tag, int s, int tg, int r, int w, int disturb);
    int p, dt, dpt;
    p  = 16 * (r + 1);
    dt = n_steps(s, tg, w) * p;
    dpt = (dt > 2) ? 1 + ($urandom % (dt - 2)) : -1;
    @(negedge clk);
    start_i = 1'b1; rate_i = 2'(r); wide_step_i = 1'(w);
    start_code_i = 8'(s); target_code_i = 8'(tg);
    for (int t = 0; t <= dt + 3; t++) begin
      @(negedge clk);
      if (t == 0) start_i = 1'b0;
      check(tag, "code", int'(code_o), exp_code(s, tg, w, p, t));
      check(t == dt ? "R6" : tag, "done", int'(done_o), (t == dt) ? 1 : 0);
      check(t > dt ? "R7" : "R2", "busy", int'(busy_o), (t < dt) ? 1 : 0);
      if (t == dpt && disturb == 1) begin
        start_i = 1'b1;
        start_code_i = 8'($urandom);
        target_code_i = 8'($urandom);
      end else if (t == dpt + 1 && disturb == 1) begin
        start_i = 1'b0;
      end
      if (t == dpt && disturb == 2) begin
        rate_i = ~rate_i;
        wide_step_i = ~wide_step_i;
      end
    end
  endtask

  initial begin
    process::self().srandom(32'd1357);
    rst_n = 1'b0; start_i = 1'b0; rate_i = '0; wide_step_i = 1'b0;
    start_code_i = '0; target_code_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "code", int'(code_o), 0);
    check("R1", "busy", int'(busy_o), 0);
    check("R1", "done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "code", int'(code_o), 0);
    check("R1", "busy", int'(busy_o), 0);
    // R3 every rate code
    for (int r = 0; r < 4; r++) run_ramp("R3", 40, 44, r, 0, 0);
    // R4 two-code step, even distance
    run_ramp("R4", 10, 18, 0, 1, 0);
    // R5 two-code step, odd distance ends on a short step
    run_ramp("R5", 10, 17, 1, 1, 0);
    run_ramp("R5", 254, 255, 0, 1, 0);
    // R9 equal and below
    run_ramp("R9", 60, 60, 2, 0, 0);
    run_ramp("R9", 90, 30, 0, 1, 0);
    // R8 start while busy
    run_ramp("R8", 5, 12, 0, 0, 1);
    // R10 inputs changed mid-ramp
    run_ramp("R10", 100, 107, 1, 0, 2);
    run_ramp("R10", 20, 29, 0, 1, 2);
    // random ramps
    for (int i = 0; i < 24; i++) begin
      int s;
      s = $urandom % 240;
      run_ramp("R3", s, s + int'($urandom % 13) - 2, int'($urandom % 4),
               int'($urandom % 2), int'($urandom % 3));
    end
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_vec++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule